// File: doc/BRIEF.md
# 16-bit Capture/Compare Timer Channel

This block is a 16-bit up-counter with two 16-bit registers beside it. Each register can be set to compare or to capture. The counter advances on a count-clock rise strobe, which comes from a prescaler outside the block. It can also advance on valid edges of trigger input A. Two counting styles are offered. In free-running mode the counter wraps at the top of its range and pulses an overflow output. In clear mode the counter returns to zero after it reaches register 0.

Two asynchronous trigger pins, A and B, pass through a synchroniser and then a sampling filter clocked by the count-clock rise strobe. The filter rejects short glitches. Each valid edge starts a capture. The counter value is latched on the next count-clock fall strobe, and the register's interrupt follows on the next rise strobe. A one-shot output is armed by a start strobe and only runs in free-running mode. Register writes are gated while the timer runs.

Every pin is a plain control or status pin. There is no data stream at the edge of the block, so there is no valid/ready handshake and no back-pressure. Write strobes and the one-shot start strobe each last one clock and are acted on in the same cycle, or dropped if they are gated.

Top module: `cct_timer16`

## Requirements
- R1: After reset, `count`, `reg0_val`, `reg1_val`, `irq0`, `irq1`, `ovf` and `os_out` are all 0.
- R2: While `run` is 1 and `count_src_a` is 0, each clock with `cnt_rise` high adds 1 to `count` (visible after that edge). From 0xFFFF the counter goes to 0 and `ovf` pulses for one clock. `count` does not change without a strobe.
- R3: With `clear_mode` = 1, a count strobe taken while `count` equals `reg0_val` loads 0 instead of adding 1. When `reg0_cap` = 0 it also pulses `irq0`. No `ovf` is produced in this mode.
- R4: A register in compare mode (`regN_cap` = 0) keeps its contents when a capture trigger arrives, and no capture interrupt is raised.
- R5: A capture latches `count` at the first `cnt_fall` strobe after the filtered edge. The register's `irq` pulses for one clock at the next `cnt_rise` strobe. If a trigger is raised while `count` = c, just before a count strobe, the register receives c+4.
- R6: A trigger level is accepted only after three consecutive equal samples taken at `cnt_rise` strobes, which means it must be stable for more than two count-clock periods. A pulse that covers only two samples is rejected.
- R7: Edge select encoding for `a_edge`/`b_edge`: 00 none, 01 rising, 10 falling, 11 both. When the selected pin's code is 11, no capture happens from that pin.
- R8: With `count_src_a` = 1, `count` advances once per valid A edge instead of on `cnt_rise`. No register triggered by A captures.
- R9: While `run` = 0, `count` is held at 0 and trigger edges are ignored. A level that is already present when `run` rises is not treated as an edge.
- R10: A write via `wr0` is ignored while `run` = 1. A write via `wr1` is ignored while `run` = 1 unless `ppg_mode` = 1. Otherwise `wdata` is loaded at that edge.
- R11: In free-running mode, an `os_start` strobe arms the one-shot. `os_out` rises on the count strobe taken at `count` = `reg1_val` and falls on the count strobe taken at `count` = `reg0_val`. In clear mode `os_out` stays 0.
- R12: Register 1 is always triggered by pin A. Register 0 is triggered by pin A when `reg0_src_a` = 1 and by pin B when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Timer running |
| cnt_rise | input | 1 | Count-clock rise phase strobe |
| cnt_fall | input | 1 | Count-clock fall phase strobe |
| clear_mode | input | 1 | 1: clear on reg0 match, 0: free-running |
| count_src_a | input | 1 | Count valid A edges instead of `cnt_rise` |
| ppg_mode | input | 1 | Allows reg1 writes while running |
| reg0_cap | input | 1 | Register 0: 1 capture, 0 compare |
| reg1_cap | input | 1 | Register 1: 1 capture, 0 compare |
| reg0_src_a | input | 1 | Register 0 trigger: 1 pin A, 0 pin B |
| a_edge | input | 2 | Valid edge select for pin A |
| b_edge | input | 2 | Valid edge select for pin B |
| trg_a | input | 1 | Asynchronous trigger pin A |
| trg_b | input | 1 | Asynchronous trigger pin B |
| wr0 | input | 1 | Write strobe for register 0 |
| wr1 | input | 1 | Write strobe for register 1 |
| wdata | input | 16 | Write data |
| os_start | input | 1 | One-shot arm strobe |
| count | output | 16 | Counter value |
| reg0_val | output | 16 | Register 0 contents |
| reg1_val | output | 16 | Register 1 contents |
| irq0 | output | 1 | Register 0 match/capture pulse |
| irq1 | output | 1 | Register 1 match/capture pulse |
| ovf | output | 1 | Free-running wrap pulse |
| os_out | output | 1 | One-shot pulse output |

## Verification
Trigger pins are driven with three kinds of pulse. A long pulse must be captured at c+4. A two-sample glitch must be rejected. A pulse sent while the timer is stopped must leave the registers untouched. Together these separate the filter depth, the fall-phase latch timing and the stop gating. The same long-pulse pattern is then repeated with both-edge select, with A as count source, and with compare mode. Only the missing capture distinguishes these runs from the capture case. Random run/ppg/write mixes are checked against a write-gating model, and a full 65536-step run shows the wrap and overflow pulse, in contrast with the clear-mode period and its match interrupts.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic edge_ok(input edge_sel_e sel, input logic is_rise);
    case (sel)
      EDGE_RISE: return is_rise;
      EDGE_FALL: return !is_rise;
      EDGE_BOTH: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cct_trig_filter.sv
module cct_trig_filter #(
  parameter int SAMPLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       pin_async,
  input  logic [1:0] sel,
  output logic       hit
);
  import cct_pkg::*;

  logic               s1, s2, lvl;
  logic [SAMPLES-1:0] hist;
  logic [SAMPLES-1:0] hist_next;
  edge_sel_e          sel_e;

  assign sel_e     = edge_sel_e'(sel);
  assign hist_next = {hist[SAMPLES-2:0], s2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_async;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      lvl  <= 1'b0;
      hit  <= 1'b0;
    end else if (!run) begin
      // stopped: follow the pin silently so a restart sees no edge
      hist <= {SAMPLES{s2}};
      lvl  <= s2;
      hit  <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (tick) begin
        hist <= hist_next;
        if ((&hist_next) && !lvl) begin
          lvl <= 1'b1;
          hit <= edge_ok(sel_e, 1'b1);
        end else if (!(|hist_next) && lvl) begin
          lvl <= 1'b0;
          hit <= edge_ok(sel_e, 1'b0);
        end
      end
    end
  end

endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         inc,
  input  logic         clear_mode,
  input  logic [W-1:0] top_val,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (!run) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (inc) begin
        if (clear_mode && count == top_val) begin
          count <= '0;
        end else begin
          count <= count + 1'b1;
          ovf   <= !clear_mode && count == MAXV;
        end
      end
    end
  end

endmodule

// File: rtl/cct_capreg.sv
module cct_capreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick_rise,
  input  logic         tick_fall,
  input  logic         inc,
  input  logic         cap_mode,
  input  logic         trig,
  input  logic         wr_ok,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] count,
  output logic [W-1:0] val,
  output logic         irq
);
  logic pend, flag, do_cap, cmp_hit;

  assign do_cap  = pend && tick_fall && cap_mode;
  assign cmp_hit = !cap_mode && inc && count == val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (wr && wr_ok) begin
      val <= wdata;
    end else if (do_cap) begin
      val <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else if (!run) begin
      pend <= 1'b0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= cap_mode && (trig || (pend && !tick_fall));
      if (do_cap)         flag <= 1'b1;
      else if (tick_rise) flag <= 1'b0;
      irq <= (flag && tick_rise) || cmp_hit;
    end
  end

endmodule

// File: rtl/cct_oneshot.sv
module cct_oneshot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear_mode,
  input  logic         start,
  input  logic         inc,
  input  logic [W-1:0] count,
  input  logic [W-1:0] set_val,
  input  logic [W-1:0] end_val,
  output logic         pulse
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pulse <= 1'b0;
    end else if (!run || clear_mode) begin
      armed <= 1'b0;
      pulse <= 1'b0;
    end else begin
      if (start && !pulse) armed <= 1'b1;
      if (armed && inc && count == set_val) begin
        pulse <= 1'b1;
        armed <= 1'b0;
      end else if (pulse && inc && count == end_val) begin
        pulse <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cct_timer16.sv
module cct_timer16 #(
  parameter int CW      = 16,
  parameter int SAMPLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cnt_rise,
  input  logic          cnt_fall,
  input  logic          clear_mode,
  input  logic          count_src_a,
  input  logic          ppg_mode,
  input  logic          reg0_cap,
  input  logic          reg1_cap,
  input  logic          reg0_src_a,
  input  logic [1:0]    a_edge,
  input  logic [1:0]    b_edge,
  input  logic          trg_a,
  input  logic          trg_b,
  input  logic          wr0,
  input  logic          wr1,
  input  logic [CW-1:0] wdata,
  input  logic          os_start,
  output logic [CW-1:0] count,
  output logic [CW-1:0] reg0_val,
  output logic [CW-1:0] reg1_val,
  output logic          irq0,
  output logic          irq1,
  output logic          ovf,
  output logic          os_out
);
  import cct_pkg::*;

  localparam int NPIN = 2;
  localparam int NREG = 2;

  logic [NPIN-1:0] pin_v, hit, pin_both;
  logic [1:0]      pin_sel [NPIN];
  logic [NREG-1:0] trig, cap_v, wr_v, wr_ok, irq_v;
  logic [CW-1:0]   val_v [NREG];
  logic            inc, a_blocked;

  assign pin_v      = {trg_b, trg_a};
  assign pin_sel[0] = a_edge;
  assign pin_sel[1] = b_edge;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign pin_both[p] = edge_sel_e'(pin_sel[p]) == EDGE_BOTH;
    cct_trig_filter #(.SAMPLES(SAMPLES)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick     (cnt_rise),
      .pin_async(pin_v[p]),
      .sel      (pin_sel[p]),
      .hit      (hit[p])
    );
  end

  assign inc       = run && (count_src_a ? hit[0] : cnt_rise);
  assign a_blocked = pin_both[0] || count_src_a;

  // register 0 picks its trigger pin, register 1 always listens to A
  assign trig[0] = reg0_src_a ? (hit[0] && !a_blocked) : (hit[1] && !pin_both[1]);
  assign trig[1] = hit[0] && !a_blocked;

  assign cap_v = {reg1_cap, reg0_cap};
  assign wr_v  = {wr1, wr0};
  assign wr_ok = {!run || ppg_mode, !run};

  cct_counter #(.W(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .inc       (inc),
    .clear_mode(clear_mode),
    .top_val   (val_v[0]),
    .count     (count),
    .ovf       (ovf)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    cct_capreg #(.W(CW)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .tick_rise(cnt_rise),
      .tick_fall(cnt_fall),
      .inc      (inc),
      .cap_mode (cap_v[r]),
      .trig     (trig[r]),
      .wr_ok    (wr_ok[r]),
      .wr       (wr_v[r]),
      .wdata    (wdata),
      .count    (count),
      .val      (val_v[r]),
      .irq      (irq_v[r])
    );
  end

  cct_oneshot #(.W(CW)) u_os (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .clear_mode(clear_mode),
    .start     (os_start),
    .inc       (inc),
    .count     (count),
    .set_val   (val_v[1]),
    .end_val   (val_v[0]),
    .pulse     (os_out)
  );

  assign reg0_val = val_v[0];
  assign reg1_val = val_v[1];
  assign irq0     = irq_v[0];
  assign irq1     = irq_v[1];

endmodule

// File: rtl/cct_timer16_chk.sv
module cct_timer16_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          cnt_rise,
  input logic          count_src_a,
  input logic          clear_mode,
  input logic          wr0,
  input logic          wr1,
  input logic          reg0_cap,
  input logic          reg1_cap,
  input logic [CW-1:0] count,
  input logic [CW-1:0] reg0_val,
  input logic [CW-1:0] reg1_val,
  input logic          os_out
);

  // R2: no count strobe, no change
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_rise && !count_src_a) |=> $stable(count));

  // R9: a stopped timer sits at zero
  a_r9_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);

  // R10: register 0 is write-locked while running
  a_r10_reg0_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr0 && !reg0_cap) |=> $stable(reg0_val));

  // R4: a compare register changes only by a write
  a_r4_compare_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg1_cap && !wr1) |=> $stable(reg1_val));

  // R11: no one-shot in clear mode
  a_r11_no_oneshot_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear_mode |=> !os_out);

endmodule

bind cct_timer16 cct_timer16_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_cct_timer16.sv
`timescale 1ns/1ps
module tb_cct_timer16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 0, cnt_rise = 0, cnt_fall = 0, clear_mode = 0;
  logic        count_src_a = 0, ppg_mode = 0, reg0_cap = 0, reg1_cap = 0;
  logic        reg0_src_a = 0;
  logic [1:0]  a_edge = 2'b00, b_edge = 2'b00;
  logic        trg_a = 0, trg_b = 0, wr0 = 0, wr1 = 0, os_start = 0;
  logic [15:0] wdata = '0;
  logic [15:0] count, reg0_val, reg1_val;
  logic        irq0, irq1, ovf, os_out;

  int total = 0, bad = 0;
  int n_irq0 = 0, n_irq1 = 0, n_ovf = 0, n_os = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cct_timer16 dut (.*);

  // free-running event counters, sampled away from the active edge
  always @(negedge clk) begin
    if (irq0)   n_irq0++;
    if (irq1)   n_irq1++;
    if (ovf)    n_ovf++;
    if (os_out) n_os++;
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one count-clock period: rise strobe, gap, fall strobe, gap
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      cnt_rise = 1; @(negedge clk);
      cnt_rise = 0; @(negedge clk);
      cnt_fall = 1; @(negedge clk);
      cnt_fall = 0; @(negedge clk);
    end
  endtask

  task automatic stop_all();
    run = 0; trg_a = 0; trg_b = 0; count_src_a = 0; clear_mode = 0;
    ppg_mode = 0; reg0_cap = 0; reg1_cap = 0; reg0_src_a = 0;
    a_edge = 2'b00; b_edge = 2'b00;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input int idx, input logic [15:0] v);
    wdata = v;
    if (idx == 0) wr0 = 1; else wr1 = 1;
    @(negedge clk);
    wr0 = 0; wr1 = 0;
  endtask

  // expected write acceptance (R10)
  function automatic bit wr_taken(input int idx, input bit r, input bit p);
    return idx == 0 ? !r : (!r || p);
  endfunction

  // long pulse pattern on A: three high/low pairs of four periods
  task automatic a_pulses();
    for (int k = 0; k < 3; k++) begin
      trg_a = 1; tick(4);
      trg_a = 0; tick(4);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b0, b1, bo, bs;
    logic [15:0] e0, e1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 reg0", reg0_val, 0);
    chk("R1 reg1", reg1_val, 0);
    chk("R1 flags", {irq0, irq1, ovf, os_out}, 0);

    // R2: steps and full wrap with overflow pulse
    stop_all();
    run = 1; @(negedge clk);
    tick(3);
    chk("R2 steps", count, 3);
    repeat (5) @(negedge clk);
    chk("R2 hold", count, 3);
    run = 0; @(negedge clk); run = 1; @(negedge clk);
    bo = n_ovf;
    cnt_rise = 1;
    repeat (65535) @(negedge clk);
    chk("R2 top", count, 16'hFFFF);
    chk("R2 no early ovf", n_ovf - bo, 0);
    @(negedge clk);
    cnt_rise = 0;
    chk("R2 wrap", count, 0);
    @(negedge clk);
    chk("R2 ovf once", n_ovf - bo, 1);

    // R3: clear-on-match period of reg0+1
    stop_all();
    wr_reg(0, 16'd5);
    clear_mode = 1; run = 1; @(negedge clk);
    b0 = n_irq0; bo = n_ovf;
    tick(20);
    chk("R3 count", count, 2);
    chk("R3 irq0", n_irq0 - b0, 3);
    chk("R3 no ovf", n_ovf - bo, 0);

    // R5 and R6: capture timing and filter on A rising
    stop_all();
    wr_reg(1, 16'h0AAA);
    reg1_cap = 1; a_edge = 2'b01; run = 1; @(negedge clk);
    b1 = n_irq1;
    tick(2);
    trg_a = 1; tick(2); trg_a = 0; tick(5);
    chk("R6 glitch rejected", reg1_val, 16'h0AAA);
    chk("R6 no irq", n_irq1 - b1, 0);
    chk("R6 count", count, 9);
    trg_a = 1; tick(4);
    chk("R5 latch c+4", reg1_val, 13);
    chk("R5 irq waits", n_irq1 - b1, 0);
    tick(1);
    chk("R5 irq pulse", n_irq1 - b1, 1);
    tick(3);
    chk("R5 single capture", reg1_val, 13);

    // R4: compare register ignores trigger
    stop_all();
    wr_reg(1, 16'h0DDD);
    a_edge = 2'b01; run = 1; @(negedge clk);
    b1 = n_irq1;
    a_pulses();
    chk("R4 kept", reg1_val, 16'h0DDD);
    chk("R4 no irq", n_irq1 - b1, 0);

    // R7: both-edge select blocks capture
    stop_all();
    wr_reg(1, 16'h0BEE);
    reg1_cap = 1; a_edge = 2'b11; run = 1; @(negedge clk);
    b1 = n_irq1;
    a_pulses();
    chk("R7 kept", reg1_val, 16'h0BEE);
    chk("R7 no irq", n_irq1 - b1, 0);

    // R8: A as count source
    stop_all();
    wr_reg(1, 16'h1234);
    wr_reg(0, 16'h7777);
    reg1_cap = 1; a_edge = 2'b01; count_src_a = 1; run = 1; @(negedge clk);
    b1 = n_irq1;
    a_pulses();
    chk("R8 edge count", count, 3);
    chk("R8 no capture", reg1_val, 16'h1234);
    chk("R8 no irq", n_irq1 - b1, 0);

    // R9: edges while stopped are ignored
    stop_all();
    wr_reg(1, 16'h0CCC);
    reg1_cap = 1; a_edge = 2'b01;
    b1 = n_irq1;
    trg_a = 1; tick(5);
    chk("R9 stopped count", count, 0);
    chk("R9 stopped reg", reg1_val, 16'h0CCC);
    run = 1; @(negedge clk);
    tick(6);
    chk("R9 level not edge", reg1_val, 16'h0CCC);
    chk("R9 no irq", n_irq1 - b1, 0);

    // R12: register 0 triggered by B falling
    stop_all();
    reg0_cap = 1; reg0_src_a = 0; b_edge = 2'b10; a_edge = 2'b01;
    wr_reg(1, 16'h0F0F);
    trg_b = 1; repeat (4) @(negedge clk);
    run = 1; @(negedge clk);
    b0 = n_irq0;
    tick(2);
    trg_b = 0; tick(4);
    chk("R12 reg0 from B", reg0_val, 6);
    tick(1);
    chk("R12 irq0", n_irq0 - b0, 1);
    chk("R12 reg1 untouched", reg1_val, 16'h0F0F);

    // R11: one-shot in free mode, none in clear mode
    stop_all();
    wr_reg(1, 16'd3);
    wr_reg(0, 16'd6);
    run = 1; @(negedge clk);
    os_start = 1; @(negedge clk); os_start = 0;
    tick(3);
    chk("R11 low before", os_out, 0);
    tick(1);
    chk("R11 rise at reg1", os_out, 1);
    tick(2);
    chk("R11 held", os_out, 1);
    tick(1);
    chk("R11 fall at reg0", os_out, 0);
    run = 0; @(negedge clk);
    clear_mode = 1; run = 1; @(negedge clk);
    bs = n_os;
    os_start = 1; @(negedge clk); os_start = 0;
    tick(12);
    chk("R11 clear mode none", n_os - bs, 0);

    // R10: random run/ppg/write mix against acceptance model
    stop_all();
    e0 = reg0_val; e1 = reg1_val;
    for (int it = 0; it < 200; it++) begin
      logic r, p, w0, w1;
      logic [15:0] d;
      r = 1'($urandom); p = 1'($urandom);
      w0 = 1'($urandom); w1 = 1'($urandom); d = 16'($urandom);
      if (it == 0) begin r = 1; p = 0; w0 = 1; w1 = 1; end
      if (it == 1) begin r = 1; p = 1; w0 = 0; w1 = 1; end
      run = r; ppg_mode = p; wr0 = w0; wr1 = w1; wdata = d;
      if (w0 && wr_taken(0, r, p)) e0 = d;
      if (w1 && wr_taken(1, r, p)) e1 = d;
      @(negedge clk);
      wr0 = 0; wr1 = 0;
      chk("R10 reg0 gate", reg0_val, e0);
      chk("R10 reg1 gate", reg1_val, e1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule